// File: doc/BRIEF.md
# Character LCD RAM Address Controller

This block is the command-decode and address-pointer stage of a character LCD controller. A host presents one-byte writes qualified by a two-bit register-select code. The block recognises the commands that point the shared address counter at the display-data RAM, the character-generator RAM or an auxiliary RAM, and the command that stores a byte at the current pointer. For each stored byte it issues a one-cycle write strobe to the RAM side, carrying the target code, the address and the byte. It then steps the pointer up or down as the `addr_dec` configuration input selects.

A single counter serves all three RAMs. Whichever address-set command arrived last decides which RAM later data bytes go to. Display-data addresses follow the line mode. In single-line mode they run as one range. In two-line mode they form two separate ranges, and the pointer jumps across the gap between them. Every accepted command holds `busy` high for a fixed number of cycles, and the host polls that flag. Writes that arrive while `busy` is high are dropped.

Top module: `lcd_addr_ctrl`

## Requirements
- R1: After a synchronous active-low reset: `busy` = 0, `ram_we` = 0, `cur_tgt` = 2'b00 (display-data RAM), `cur_addr` = 0.
- R2: A write with `bus_rs` = 2'b10 and `bus_data[7]` = 1 loads `cur_addr` with `bus_data[6:0]` and sets `cur_tgt` to 2'b00 (display-data RAM).
- R3: A write with `bus_rs` = 2'b10 and `bus_data[7:6]` = 2'b01 loads `cur_addr` with `{1'b0, bus_data[5:0]}` and sets `cur_tgt` to 2'b01 (character-generator RAM).
- R4: A write with `bus_rs` = 2'b01 loads `cur_addr` with `{1'b0, bus_data[5:0]}` and sets `cur_tgt` to 2'b10 (auxiliary RAM).
- R5: A write with `bus_rs` = 2'b11 raises `ram_we` for exactly the next cycle. In that cycle `ram_tgt` is the selected target, `ram_addr` is the pointer value before the step, and `ram_wdata` is the byte.
- R6: After a data write with target 2'b01 or 2'b10, the pointer moves by +1 (`addr_dec` = 0) or -1 (`addr_dec` = 1) modulo 64, and bit 6 stays 0.
- R7: After a display-data write with `line2_mode` = 0, incrementing goes from 0x4F to 0x00 and decrementing goes from 0x00 to 0x4F. Any other value moves by ±1 modulo 128.
- R8: After a display-data write with `line2_mode` = 1, incrementing goes 0x27→0x40 and 0x67→0x00, and decrementing goes 0x40→0x27 and 0x00→0x67. Any other value moves by ±1 modulo 128.
- R9: Each accepted command (R2–R5) drives `busy` high from the next cycle for exactly BUSY_CYC cycles (default 10).
- R10: A write presented while `busy` = 1 has no effect: no strobe, and pointer and target are unchanged.
- R11: Writes with `bus_rs` = 2'b00, or with `bus_rs` = 2'b10 and `bus_data[7:6]` = 2'b00, are ignored: `busy` stays 0, there is no strobe, and the state is unchanged.
- R12: The selected target persists across any number of data writes until another address-set command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Host write valid for this cycle |
| bus_rs | input | 2 | Register-select code of the host write |
| bus_data | input | 8 | Host write byte |
| line2_mode | input | 1 | 1 = two-line display-data layout |
| addr_dec | input | 1 | 1 = step pointer downward after a data write |
| busy | output | 1 | Command in execution; host writes are dropped |
| ram_we | output | 1 | One-cycle RAM write strobe |
| ram_tgt | output | 2 | RAM target of the strobe (00 display, 01 char-gen, 10 auxiliary) |
| ram_addr | output | 7 | RAM address of the strobe |
| ram_wdata | output | 8 | RAM write byte |
| cur_tgt | output | 2 | Currently selected target |
| cur_addr | output | 7 | Current pointer value |

## Verification
Directed sequences place the pointer on every jump point of both display-data layouts and at both ends of the 6-bit range. Each is stepped in both directions, so an off-by-one jump or a missing wrap is caught. Separate runs present unused select codes, unused command bytes and writes timed inside the busy window, which distinguishes commands that are truly dropped from commands that leak into the state. A long random mix of commands, line modes and directions then checks that the target persists across writes and that every strobe carries the expected target, address and data.

// File: rtl/lcd_addr_pkg.sv
// Shared widths, target codes, command kinds and display-data jump points
// for the LCD RAM address controller.
package lcd_addr_pkg;
    localparam int DATA_W = 8;
    localparam int DD_AW  = 7;
    localparam int CG_AW  = 6;

    localparam logic [DD_AW-1:0] DD_ONE_LAST  = 7'h4F;
    localparam logic [DD_AW-1:0] DD_TWO_END0  = 7'h27;
    localparam logic [DD_AW-1:0] DD_TWO_BASE1 = 7'h40;
    localparam logic [DD_AW-1:0] DD_TWO_END1  = 7'h67;

    typedef enum logic [1:0] {
        TGT_DD  = 2'b00,
        TGT_CG  = 2'b01,
        TGT_AUX = 2'b10
    } tgt_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_SET_DD,
        CMD_SET_CG,
        CMD_SET_AUX,
        CMD_WRITE
    } cmd_e;
endpackage

// File: rtl/lcd_cmd_decode.sv
// Classifies one host write from its select code and byte.
// Assumes: purely combinational; acceptance gating is done by the caller.
module lcd_cmd_decode
    import lcd_addr_pkg::*;
(
    input  logic [1:0]        rs,
    input  logic [DATA_W-1:0] data,
    output cmd_e              cmd
);
    // Map select code and top bits of the byte onto a command kind.
    always_comb begin
        cmd = CMD_NONE;
        unique case (rs)
            2'b11: cmd = CMD_WRITE;
            2'b01: cmd = CMD_SET_AUX;
            2'b10: begin
                if (data[DATA_W-1])
                    cmd = CMD_SET_DD;
                else if (data[DATA_W-2])
                    cmd = CMD_SET_CG;
            end
            default: cmd = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/lcd_addr_step.sv
// Computes the pointer value that follows a data write, for the given
// target, line layout and direction.
// Assumes: narrow targets keep their upper pointer bits at zero.
module lcd_addr_step
    import lcd_addr_pkg::*;
(
    input  logic [DD_AW-1:0] addr,
    input  tgt_e             tgt,
    input  logic             line2,
    input  logic             dec,
    output logic [DD_AW-1:0] nxt
);
    localparam logic [DD_AW-1:0] ONE = DD_AW'(1);
    localparam logic [CG_AW-1:0] ONE_N = CG_AW'(1);

    logic [CG_AW-1:0] low_nxt;

    // Narrow targets: plain modulo-64 step.
    always_comb begin
        low_nxt = dec ? (addr[CG_AW-1:0] - ONE_N) : (addr[CG_AW-1:0] + ONE_N);
    end

    // Choose the step rule for the active target and layout.
    always_comb begin
        if (tgt != TGT_DD) begin
            nxt = DD_AW'(low_nxt);
        end else if (line2) begin
            if (!dec) begin
                if (addr == DD_TWO_END0)      nxt = DD_TWO_BASE1;
                else if (addr == DD_TWO_END1) nxt = '0;
                else                          nxt = addr + ONE;
            end else begin
                if (addr == DD_TWO_BASE1)     nxt = DD_TWO_END0;
                else if (addr == '0)          nxt = DD_TWO_END1;
                else                          nxt = addr - ONE;
            end
        end else begin
            if (!dec) nxt = (addr == DD_ONE_LAST) ? '0 : addr + ONE;
            else      nxt = (addr == '0) ? DD_ONE_LAST : addr - ONE;
        end
    end
endmodule

// File: rtl/lcd_busy_timer.sv
// Holds busy for a fixed number of cycles after each start pulse.
// Assumes: start only arrives while busy is low.
module lcd_busy_timer #(
    parameter int BUSY_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(BUSY_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    // Busy while the count is non-zero.
    always_comb busy = (cnt_q != '0);
endmodule

// File: rtl/lcd_addr_ctrl.sv
// Command decode and shared address pointer for the display-data,
// character-generator and auxiliary RAMs of a character LCD controller.
// Assumes: host waits for busy low; RAM side accepts a strobe every cycle.
module lcd_addr_ctrl
    import lcd_addr_pkg::*;
#(
    parameter int BUSY_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_rs,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              line2_mode,
    input  logic              addr_dec,
    output logic              busy,
    output logic              ram_we,
    output logic [1:0]        ram_tgt,
    output logic [DD_AW-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [1:0]        cur_tgt,
    output logic [DD_AW-1:0]  cur_addr
);
    cmd_e              cmd;
    logic              accept;
    tgt_e              tgt_q;
    logic [DD_AW-1:0]  addr_q;
    logic [DD_AW-1:0]  addr_nxt;
    logic              we_q;
    tgt_e              wtgt_q;
    logic [DD_AW-1:0]  waddr_q;
    logic [DATA_W-1:0] wdata_q;

    lcd_cmd_decode u_dec (
        .rs   (bus_rs),
        .data (bus_data),
        .cmd  (cmd)
    );

    lcd_addr_step u_step (
        .addr  (addr_q),
        .tgt   (tgt_q),
        .line2 (line2_mode),
        .dec   (addr_dec),
        .nxt   (addr_nxt)
    );

    lcd_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .busy  (busy)
    );

    // A command is taken only when recognised and not busy.
    always_comb accept = bus_we && !busy && (cmd != CMD_NONE);

    // Update target/pointer and launch the RAM strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q   <= TGT_DD;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wtgt_q  <= TGT_DD;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            we_q <= 1'b0;
            if (accept) begin
                unique case (cmd)
                    CMD_SET_DD: begin
                        tgt_q  <= TGT_DD;
                        addr_q <= bus_data[DD_AW-1:0];
                    end
                    CMD_SET_CG: begin
                        tgt_q  <= TGT_CG;
                        addr_q <= DD_AW'(bus_data[CG_AW-1:0]);
                    end
                    CMD_SET_AUX: begin
                        tgt_q  <= TGT_AUX;
                        addr_q <= DD_AW'(bus_data[CG_AW-1:0]);
                    end
                    CMD_WRITE: begin
                        we_q    <= 1'b1;
                        wtgt_q  <= tgt_q;
                        waddr_q <= addr_q;
                        wdata_q <= bus_data;
                        addr_q  <= addr_nxt;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        ram_we    = we_q;
        ram_tgt   = wtgt_q;
        ram_addr  = waddr_q;
        ram_wdata = wdata_q;
        cur_tgt   = tgt_q;
        cur_addr  = addr_q;
    end
endmodule

// File: rtl/lcd_addr_ctrl_chk.sv
// Protocol checker for lcd_addr_ctrl, attached by bind.
// Assumes: line2_mode only changes while no command is in flight.
module lcd_addr_ctrl_chk #(
    parameter int BUSY_CYC = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [1:0] bus_rs,
    input logic [7:0] bus_data,
    input logic       line2_mode,
    input logic       busy,
    input logic       ram_we,
    input logic [1:0] ram_tgt,
    input logic [6:0] ram_addr,
    input logic [1:0] cur_tgt,
    input logic [6:0] cur_addr
);
    logic known;
    int   run_q;

    // Recognised command kinds, written independently of the decoder.
    always_comb known = (bus_rs == 2'b11) || (bus_rs == 2'b01) ||
                        (bus_rs == 2'b10 && bus_data[7:6] != 2'b00);

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    function automatic logic in_two(input logic [6:0] a);
        return (a <= 7'h27) || (a >= 7'h40 && a <= 7'h67);
    endfunction

    a_r9_busy_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !busy && known) |=> busy);

    a_r9_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= BUSY_CYC);

    a_r5_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(bus_we && !busy && bus_rs == 2'b11));

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && busy) |=> (!ram_we && $stable(cur_addr) && $stable(cur_tgt)));

    a_r11_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !busy && !known) |=> (!busy && !ram_we && $stable(cur_addr) && $stable(cur_tgt)));

    a_r6_narrow_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_tgt != 2'b00) |-> (cur_addr[6] == 1'b0));

    a_r8_two_line_stays_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_tgt == 2'b00 && line2_mode && in_two(ram_addr)) |-> in_two(cur_addr));
endmodule

bind lcd_addr_ctrl lcd_addr_ctrl_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_rs     (bus_rs),
    .bus_data   (bus_data),
    .line2_mode (line2_mode),
    .busy       (busy),
    .ram_we     (ram_we),
    .ram_tgt    (ram_tgt),
    .ram_addr   (ram_addr),
    .cur_tgt    (cur_tgt),
    .cur_addr   (cur_addr)
);

// File: tb/lcd_addr_ctrl_bench.sv
module lcd_addr_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY_CYC   = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_we;
    logic [1:0] bus_rs;
    logic [7:0] bus_data;
    logic       line2_mode;
    logic       addr_dec;
    logic       busy;
    logic       ram_we;
    logic [1:0] ram_tgt;
    logic [6:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [1:0] cur_tgt;
    logic [6:0] cur_addr;

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;

    logic [1:0] m_tgt;
    logic [6:0] m_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_addr_ctrl #(.BUSY_CYC(BUSY_CYC)) u_lcd_addr_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_rs(bus_rs),
        .bus_data(bus_data), .line2_mode(line2_mode), .addr_dec(addr_dec),
        .busy(busy), .ram_we(ram_we), .ram_tgt(ram_tgt), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .cur_tgt(cur_tgt), .cur_addr(cur_addr)
    );

    always @(negedge clk) if (ram_we) we_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // 0 none, 1 dd, 2 cg, 3 aux, 4 write
    function automatic int kind_of(input logic [1:0] rs, input logic [7:0] d);
        if (rs == 2'b11) return 4;
        if (rs == 2'b01) return 3;
        if (rs == 2'b10 && d[7]) return 1;
        if (rs == 2'b10 && d[7:6] == 2'b01) return 2;
        return 0;
    endfunction

    function automatic logic [6:0] next_of(input logic [1:0] t, input logic [6:0] a,
                                           input logic two, input logic dn);
        int v;
        if (t != 2'b00) begin
            v = dn ? int'(a) - 1 : int'(a) + 1;
            return 7'((v + 64) % 64);
        end
        if (two && !dn && a == 7'h27) return 7'h40;
        if (two && !dn && a == 7'h67) return 7'h00;
        if (two && dn && a == 7'h40)  return 7'h27;
        if (two && dn && a == 7'h00)  return 7'h67;
        if (!two && !dn && a == 7'h4F) return 7'h00;
        if (!two && dn && a == 7'h00)  return 7'h4F;
        v = dn ? int'(a) - 1 : int'(a) + 1;
        return 7'((v + 128) % 128);
    endfunction

    // Issue one command; optionally poke a write while busy.
    task automatic issue(input logic [1:0] rs, input logic [7:0] d, input bit poke);
        int k, n, we0;
        logic [6:0] nx;
        k   = kind_of(rs, d);
        we0 = we_cnt;
        @(negedge clk);
        bus_we = 1'b1; bus_rs = rs; bus_data = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (k == 4) begin
            check(ram_we === 1'b1, "R5 strobe", int'(ram_we), 1);
            check(ram_tgt === m_tgt, "R5/R12 strobe target", int'(ram_tgt), int'(m_tgt));
            check(ram_addr === m_addr, "R5 strobe address", int'(ram_addr), int'(m_addr));
            check(ram_wdata === d, "R5 strobe data", int'(ram_wdata), int'(d));
            nx = next_of(m_tgt, m_addr, line2_mode, addr_dec);
            m_addr = nx;
        end else if (k == 1) begin
            m_tgt = 2'b00; m_addr = d[6:0];
        end else if (k == 2) begin
            m_tgt = 2'b01; m_addr = {1'b0, d[5:0]};
        end else if (k == 3) begin
            m_tgt = 2'b10; m_addr = {1'b0, d[5:0]};
        end
        check(cur_tgt === m_tgt, (k == 0) ? "R11 target" : "R2/R3/R4/R12 target",
              int'(cur_tgt), int'(m_tgt));
        check(cur_addr === m_addr,
              (k == 4) ? ((m_tgt != 2'b00) ? "R6 step" : (line2_mode ? "R8 step" : "R7 step"))
                       : ((k == 0) ? "R11 address" : "R2/R3/R4 address"),
              int'(cur_addr), int'(m_addr));
        if (k == 0) begin
            check(busy === 1'b0, "R11 busy", int'(busy), 0);
        end else begin
            n = 0;
            if (poke) begin
                bus_we = 1'b1; bus_rs = 2'b11; bus_data = 8'hA5;
                @(negedge clk);
                bus_we = 1'b1; bus_rs = 2'b10; bus_data = 8'h93;
                n = 1;
                @(negedge clk);
                bus_we = 1'b0;
                n = 2;
            end
            while (busy === 1'b1 && n < 4 * BUSY_CYC) begin
                @(negedge clk);
                n++;
            end
            check(n == BUSY_CYC, "R9 busy length", n, BUSY_CYC);
            if (poke) begin
                check(cur_tgt === m_tgt, "R10 target kept", int'(cur_tgt), int'(m_tgt));
                check(cur_addr === m_addr, "R10 address kept", int'(cur_addr), int'(m_addr));
            end
        end
        check(we_cnt - we0 == ((k == 4) ? 1 : 0), (poke ? "R10 strobes" : "R5/R11 strobes"),
              we_cnt - we0, (k == 4) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bus_we = 1'b0; bus_rs = 2'b00; bus_data = 8'h00;
        line2_mode = 1'b0; addr_dec = 1'b0; rst_n = 1'b0;
        m_tgt = 2'b00; m_addr = 7'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0, "R1 busy", int'(busy), 0);
        check(ram_we === 1'b0, "R1 strobe", int'(ram_we), 0);
        check(cur_tgt === 2'b00, "R1 target", int'(cur_tgt), 0);
        check(cur_addr === 7'h00, "R1 address", int'(cur_addr), 0);

        // R3/R6 char-gen wrap both ways
        issue(2'b10, 8'h7F, 1'b0);
        issue(2'b11, 8'h11, 1'b0);
        addr_dec = 1'b1;
        issue(2'b11, 8'h22, 1'b0);
        issue(2'b11, 8'h33, 1'b0);
        // R4 auxiliary
        addr_dec = 1'b0;
        issue(2'b01, 8'hFE, 1'b0);
        issue(2'b11, 8'h44, 1'b0);
        // R8 two-line jumps
        line2_mode = 1'b1;
        issue(2'b10, 8'hA7, 1'b0);
        issue(2'b11, 8'h01, 1'b0);
        issue(2'b10, 8'hE7, 1'b0);
        issue(2'b11, 8'h02, 1'b0);
        addr_dec = 1'b1;
        issue(2'b11, 8'h03, 1'b0);
        issue(2'b10, 8'hC0, 1'b0);
        issue(2'b11, 8'h04, 1'b0);
        // R7 one-line wrap
        line2_mode = 1'b0;
        issue(2'b10, 8'h80, 1'b0);
        issue(2'b11, 8'h05, 1'b0);
        addr_dec = 1'b0;
        issue(2'b11, 8'h06, 1'b0);
        // R11 unused codes
        issue(2'b00, 8'hC3, 1'b0);
        issue(2'b10, 8'h25, 1'b0);
        // R10 writes while busy
        issue(2'b01, 8'h05, 1'b1);
        issue(2'b11, 8'h77, 1'b1);

        // Random mix (R12 persistence across writes)
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 600; i++) begin
            logic [1:0] rs;
            logic [7:0] d;
            line2_mode = 1'($urandom_range(0, 1));
            addr_dec   = 1'($urandom_range(0, 1));
            rs = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 2) != 0) rs = 2'b11;
            d = 8'($urandom_range(0, 255));
            issue(rs, d, ($urandom_range(0, 15) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule